// File: doc/BRIEF.md
# Idle-Timeout Auto-Latching Configuration Shift Register

This block holds a long serial configuration word. An external controller shifts bits in on a slow shift clock with its own serial input. The bit at the top of the chain is always visible on a serial output, so several of these registers can be daisy-chained. No strobe is needed to commit the word. The block samples the shift clock with a free-running system clock and times the silence after the last shift edge. Once the shift clock has stayed quiet for a parameterised number of system-clock cycles, the block copies the whole register into a parallel holding latch, on its own.

A second configuration path can overwrite the top 17 bits of the register in one cycle. That write is accepted only while no automatic copy is pending. A write that arrives during the pending window is dropped and sets a sticky error flag. A `busy_o` output shows the pending window, so the other path can tell when it may write.

Top module: `idle_latch_sreg`

## Requirements
- R1: After reset, `latch_o`, `sdo_o`, `busy_o` and `err_o` are all zero.
- R2: Each rising edge of `sck_i`, as seen through the synchronizer, moves the register one place toward bit WIDTH-1 and puts `sdi_i` into bit 0.
- R3: `sdo_o` always shows bit WIDTH-1 of the register.
- R4: The register is copied into `latch_o` exactly TIMEOUT_CYC system-clock cycles after the last detected shift edge. After a single isolated edge, `busy_o` is high for exactly TIMEOUT_CYC cycles.
- R5: Every detected shift edge restarts the idle count. A pause shorter than TIMEOUT_CYC between edges causes no copy.
- R6: A copy happens only if at least one shift edge has been seen since the previous copy. With no new edge, `busy_o` stays low and `latch_o` keeps its value.
- R7: `busy_o` rises in the cycle after a detected shift edge and stays high until the copy.
- R8: While `busy_o` is low and no shift edge is detected, a cycle with `pload_valid_i` high writes `pload_data_i[16:0]` into register bits WIDTH-1 down to WIDTH-17, with data bit 0 going to bit WIDTH-17. The lower bits are left unchanged. This write does not start a copy and does not set `err_o`.
- R9: A cycle with `pload_valid_i` high while `busy_o` is high leaves the register unchanged. It sets `err_o`, which then stays high until reset.
- R10: `latch_o` changes only in the cycle in which `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial shift clock, asynchronous to clk_i |
| sdi_i | input | 1 | Serial data in, sampled on sck_i rising edge |
| sdo_o | output | 1 | Serial data out, top bit of the register |
| pload_valid_i | input | 1 | Parallel top-bits write request |
| pload_data_i | input | 17 | Parallel write data for the top 17 bits |
| latch_o | output | WIDTH | Committed parallel copy of the register |
| busy_o | output | 1 | Automatic copy pending |
| err_o | output | 1 | Sticky flag: write request arrived while busy |

## Verification
The hardest case to reach is the exact length of the idle window. Inside a long burst, every edge restarts the timer, so the end of the window depends on the synchronizer delay of the last edge. The bench therefore sends a single isolated edge from idle and counts the samples in which `busy_o` is high; the count must equal TIMEOUT_CYC. The bench also holds a pause just short of the timeout inside a burst, and lands a parallel write in the pending window so that the write is dropped and the register contents can be checked through `sdo_o` and the later copy.

// File: rtl/idle_latch_pkg.sv
package idle_latch_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } sreg_op_e;
endpackage

// File: rtl/sck_sync.sv
module sck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sck_q, sdi_q;
  logic              sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      sdi_q <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      sdi_q <= {sdi_q[STAGES-2:0], sdi_i};
      sck_d <= sck_q[STAGES-1];
    end
  end

  // data travels the same number of stages as the clock, so it stays aligned
  assign rise_o = sck_q[STAGES-1] & ~sck_d;
  assign sdi_o  = sdi_q[STAGES-1];
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int unsigned TIMEOUT_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic busy_o,
  output logic fire_o
);
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  // a shift edge wins over an expiring count
  assign fire_o = pend_q & ~kick_i & (cnt_q == LAST);
  assign busy_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end else if (fire_o) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_shreg.sv
module cfg_shreg
  import idle_latch_pkg::*;
#(
  parameter int unsigned WIDTH   = 216,
  parameter int unsigned PLOAD_W = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sreg_op_e           op_i,
  input  logic               sdi_i,
  input  logic [PLOAD_W-1:0] load_i,
  output logic [WIDTH-1:0]   q_o
);
  localparam int unsigned TOP = WIDTH - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (op_i)
        OP_SHIFT: q_o <= {q_o[TOP-1:0], sdi_i};
        OP_LOAD:  q_o[TOP -: PLOAD_W] <= load_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/idle_latch_sreg.sv
module idle_latch_sreg
  import idle_latch_pkg::*;
#(
  parameter int unsigned WIDTH       = 216,
  parameter int unsigned PLOAD_W     = 17,
  parameter int unsigned TIMEOUT_CYC = 500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic               pload_valid_i,
  input  logic [PLOAD_W-1:0] pload_data_i,
  output logic [WIDTH-1:0]   latch_o,
  output logic               busy_o,
  output logic               err_o
);
  logic             shift_edge, sdi_s, fire;
  logic [WIDTH-1:0] sreg_q;
  sreg_op_e         op;

  sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .sdi_i (sdi_i),
    .rise_o(shift_edge),
    .sdi_o (sdi_s)
  );

  idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(shift_edge),
    .busy_o(busy_o),
    .fire_o(fire)
  );

  always_comb begin
    if (shift_edge)                   op = OP_SHIFT;
    else if (pload_valid_i && !busy_o) op = OP_LOAD;
    else                              op = OP_HOLD;
  end

  cfg_shreg #(.WIDTH(WIDTH), .PLOAD_W(PLOAD_W)) u_sreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op),
    .sdi_i (sdi_s),
    .load_i(pload_data_i),
    .q_o   (sreg_q)
  );

  assign sdo_o = sreg_q[WIDTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (fire)                    latch_o <= sreg_q;
      if (pload_valid_i && busy_o) err_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/idle_latch_sreg_chk.sv
module idle_latch_sreg_chk #(
  parameter int unsigned W = 216
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         shift_edge,
  input logic         pload_valid_i,
  input logic         busy_o,
  input logic         err_o,
  input logic [W-1:0] sreg_q,
  input logic [W-1:0] latch_o
);
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_edge |=> sreg_q[W-1:1] == $past(sreg_q[W-2:0]));

  p_fall_copies_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> latch_o == $past(sreg_q));

  p_edge_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_edge |=> busy_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !shift_edge) |=> !busy_o);

  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_valid_i && busy_o) |=> err_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> $stable(latch_o));
endmodule

bind idle_latch_sreg idle_latch_sreg_chk #(.W(WIDTH)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .shift_edge   (shift_edge),
  .pload_valid_i(pload_valid_i),
  .busy_o       (busy_o),
  .err_o        (err_o),
  .sreg_q       (sreg_q),
  .latch_o      (latch_o)
);

// File: tb/idle_latch_sreg_tb_top.sv
module idle_latch_sreg_tb_top;
  localparam int unsigned W  = 216;
  localparam int unsigned LW = 17;
  localparam int unsigned T  = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0, sdi = 1'b0, pvalid = 1'b0;
  logic [LW-1:0] pdata = '0;
  logic          sdo, busy, err;
  logic [W-1:0]  latch;

  logic [W-1:0]  m_reg = '0, m_latch = '0;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  idle_latch_sreg #(.WIDTH(W), .PLOAD_W(LW), .TIMEOUT_CYC(T), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
    .pload_valid_i(pvalid), .pload_data_i(pdata),
    .latch_o(latch), .busy_o(busy), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_n(3);
    sck = 1'b1;
    wait_n(4);
    sck = 1'b0;
    wait_n(4);
    m_reg = {m_reg[W-2:0], b};
    check(sdo == m_reg[W-1], "R2/R3 sdo after shift", W'(sdo), W'(m_reg[W-1]));
  endtask

  task automatic send_burst(input int n);
    for (int i = 0; i < n; i++) send_bit(1'($urandom));
  endtask

  task automatic pload(input logic [LW-1:0] d);
    pdata  = d;
    pvalid = 1'b1;
    wait_n(1);
    pvalid = 1'b0;
    wait_n(1);
  endtask

  task automatic finish_copy;
    wait_n(T / 2);
    check(busy == 1'b1, "R7 busy while pending", W'(busy), W'(1));
    check(latch == m_latch, "R10 latch held while pending", latch, m_latch);
    wait_n(T);
    m_latch = m_reg;
    check(busy == 1'b0, "R4 busy cleared", W'(busy), W'(0));
    check(latch == m_latch, "R4 copy contents", latch, m_latch);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1
    check(latch == '0, "R1 latch reset", latch, '0);
    check({sdo, busy, err} == 3'b000, "R1 flags reset", W'({sdo, busy, err}), '0);

    // R6: no edge, no copy
    wait_n(2 * T);
    check(busy == 1'b0, "R6 idle no busy", W'(busy), '0);
    check(latch == '0, "R6 idle no copy", latch, '0);

    // R4: exact window after a single isolated edge
    begin
      int cnt = 0;
      sdi = 1'b1;
      wait_n(3);
      sck = 1'b1;
      for (int k = 0; k < 3 * T; k++) begin
        @(negedge clk);
        if (k == 4) sck = 1'b0;
        if (busy) cnt++;
        else if (cnt > 0) break;
      end
      m_reg = {m_reg[W-2:0], 1'b1};
      m_latch = m_reg;
      check(cnt == T, "R4 busy length", W'(cnt), W'(T));
      check(latch == m_latch, "R4 single edge copy", latch, m_latch);
    end

    // R2/R3/R4: full-width random bursts
    for (int b = 0; b < 3; b++) begin
      send_burst(W);
      finish_copy();
      wait_n(2 * T);
      check(busy == 1'b0 && latch == m_latch, "R6 one copy per burst", latch, m_latch);
    end

    // R5: pause shorter than the timeout inside a burst
    send_burst(5);
    wait_n(T - 40);
    check(busy == 1'b1, "R5 busy held across short gap", W'(busy), W'(1));
    check(latch == m_latch, "R5 no copy in short gap", latch, m_latch);
    send_burst(5);
    finish_copy();

    // R8: accepted parallel write, revealed through sdo
    begin
      logic [LW-1:0] d = 17'h1_5A3C;
      pload(d);
      m_reg[W-1 -: LW] = d;
      check(sdo == d[LW-1], "R8 load top bit", W'(sdo), W'(d[LW-1]));
      check(err == 1'b0, "R8 no error on legal load", W'(err), '0);
      wait_n(T + 10);
      check(busy == 1'b0 && latch == m_latch, "R8 load starts no copy", latch, m_latch);
      for (int i = 0; i < LW; i++) send_bit(1'b0);
      finish_copy();
    end

    // R9: write during pending window is dropped
    send_burst(8);
    check(busy == 1'b1, "R9 setup busy", W'(busy), W'(1));
    pload(~m_reg[W-1 -: LW]);
    check(err == 1'b1, "R9 err set", W'(err), W'(1));
    check(sdo == m_reg[W-1], "R9 register untouched", W'(sdo), W'(m_reg[W-1]));
    finish_copy();
    send_burst(4);
    finish_copy();
    check(err == 1'b1, "R9 err sticky", W'(err), W'(1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule